// File: doc/BRIEF.md
# Streaming 3x3 Multi-Map Convolution Engine

This block consumes a raster-ordered pixel stream that carries one signed fixed-point sample from each of several input feature maps per beat. It produces one output feature-map pixel for every position where a full 3x3 window fits inside the image. Two rows of history per input map are kept in on-chip line buffers. Every arriving pixel is therefore fetched once and reused by all nine window positions that cover it. Each window is multiplied tap by tap with a per-map 3x3 filter, and all products from all input maps are summed into one accumulator.

The sum is rounded, saturated to 16 bits and passed through a leaky rectifier. The rectifier has a programmable Q0.8 negative slope. Filter coefficients are loaded through a single-word write port while the stream is idle. Both streams use valid/ready handshakes. A start-of-frame flag on the first pixel of a frame restarts row and column tracking and clears the line buffers.

Top module: `conv_win_engine`

## Requirements
- R1: While reset is asserted and after its release, `out_valid_o` is low and `in_ready_o` is high.
- R2: A write with `coef_we_i` high stores `coef_data_i` (10-bit signed) as the coefficient at index `coef_addr_i = m*9 + r*3 + c`. Here m is the input map, r is the window row (0 = oldest row) and c is the window column (0 = leftmost).
- R3: For the window ending at pixel (x, y), the accumulator equals the sum over m, r, c of pixel[m][y-2+r][x-2+c] * coef[m*9+r*3+c]. Pixels are 10-bit signed, products are 20 bits, and nothing overflows.
- R4: No output is produced for pixels in rows 0 and 1 of a frame. The first output follows the (2*W+3)-th accepted pixel, where W is the image width.
- R5: Pixels in columns 0 and 1 produce no output. A full frame of H rows yields exactly (H-2)*(W-2) outputs, in raster order.
- R6: A pixel accepted with `in_sof_i` high is treated as row 0, column 0 of a new frame, and no earlier data reaches later outputs.
- R7: The accumulator is rounded as floor((acc + 2^(S-1)) / 2^S), with S = `RND_SH` (default 4), and then saturated to [-32768, 32767].
- R8: A rounded value y > 0 is output unchanged. A value y <= 0 is output as floor(y * `slope_i` / 256).
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output holds its value, `in_ready_o` is low, and no data is lost.
- R10: An output becomes valid in the cycle after the accepted pixel that completes its window, and never without such an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 6 | Coefficient index m*9+r*3+c |
| coef_data_i | input | 10 | Signed coefficient value |
| slope_i | input | 8 | Negative slope, unsigned Q0.8 |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_sof_i | input | 1 | First pixel of a frame |
| in_data_i | input | 40 | One 10-bit signed pixel per input map, map m at bits m*10 |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 16 | Signed output pixel |

## Verification
On every cycle, the assertions check the handshake rules: output hold under back-pressure, ready low only when stalled, and outputs appearing only after an accept. Against an independent row and column count, they also check that no output follows a pixel in the first two rows, in the first two columns, or flagged as start of frame. The arithmetic cannot be seen by a property. This covers coefficient addressing, the cross-map sum, rounding ties, both saturation limits and the rectifier slope. The bench scenarios show these by comparing every output with a value computed from the frame and coefficients. The scenarios also cover a truncated frame followed by a restart, and the latency of the first output.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int KSIZE   = 3;
  localparam int TAPS    = KSIZE * KSIZE;
  localparam int SLOPE_W = 8;
endpackage

// File: rtl/cw_line_window.sv
module cw_line_window
  import cw_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int PIX_W = 10,
  parameter int COL_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic                     clear_i,
  input  logic [COL_W-1:0]         col_i,
  input  logic [PIX_W-1:0]         px_i,
  output logic [TAPS*PIX_W-1:0]    win_o
);
  logic [PIX_W-1:0] lb1_q [IMG_W];
  logic [PIX_W-1:0] lb2_q [IMG_W];
  logic [PIX_W-1:0] c0_q  [KSIZE];
  logic [PIX_W-1:0] c1_q  [KSIZE];
  logic [PIX_W-1:0] cn    [KSIZE];

  // newest column: row 0 oldest, row 2 incoming pixel
  always_comb begin
    cn[0] = clear_i ? '0 : lb2_q[col_i];
    cn[1] = clear_i ? '0 : lb1_q[col_i];
    cn[2] = px_i;
  end

  for (genvar r = 0; r < KSIZE; r++) begin : g_row
    assign win_o[(r*KSIZE+0)*PIX_W +: PIX_W] = c0_q[r];
    assign win_o[(r*KSIZE+1)*PIX_W +: PIX_W] = c1_q[r];
    assign win_o[(r*KSIZE+2)*PIX_W +: PIX_W] = cn[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < IMG_W; i++) begin
        lb1_q[i] <= '0;
        lb2_q[i] <= '0;
      end
      for (int r = 0; r < KSIZE; r++) begin
        c0_q[r] <= '0;
        c1_q[r] <= '0;
      end
    end else if (shift_i) begin
      if (clear_i) begin
        for (int i = 0; i < IMG_W; i++) begin
          lb1_q[i] <= '0;
          lb2_q[i] <= '0;
        end
      end
      lb2_q[col_i] <= cn[1];
      lb1_q[col_i] <= px_i;
      for (int r = 0; r < KSIZE; r++) begin
        c0_q[r] <= clear_i ? '0 : c1_q[r];
        c1_q[r] <= cn[r];
      end
    end
  end
endmodule

// File: rtl/cw_mac.sv
module cw_mac
  import cw_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int PIX_W  = 10,
  parameter int COEF_W = 10,
  parameter int PROD_W = 20,
  parameter int ACC_W  = 26
) (
  input  logic [N_IN*TAPS*PIX_W-1:0]  win_i,
  input  logic [N_IN*TAPS*COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0]     acc_o
);
  localparam int NP = N_IN * TAPS;

  logic signed [PROD_W-1:0] prod [NP];

  for (genvar i = 0; i < NP; i++) begin : g_prod
    assign prod[i] = $signed(win_i[i*PIX_W +: PIX_W]) * $signed(coef_i[i*COEF_W +: COEF_W]);
  end

  always_comb begin
    logic signed [ACC_W-1:0] sum;
    sum = '0;
    for (int i = 0; i < NP; i++) sum = sum + ACC_W'(prod[i]);
    acc_o = sum;
  end
endmodule

// File: rtl/cw_post.sv
module cw_post
  import cw_pkg::*;
#(
  parameter int ACC_W  = 26,
  parameter int OUT_W  = 16,
  parameter int RND_SH = 4
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [SLOPE_W-1:0]      slope_i,
  output logic signed [OUT_W-1:0] res_o
);
  localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) <<< (RND_SH - 1);
  localparam logic signed [ACC_W:0] SMAX = (ACC_W+1)'((1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W:0] SMIN = -SMAX - (ACC_W+1)'(1);

  logic signed [ACC_W:0]           rnd;
  logic signed [ACC_W:0]           shr;
  logic signed [OUT_W-1:0]         sat;
  logic signed [OUT_W+SLOPE_W:0]   scl;

  always_comb begin
    rnd = $signed({acc_i[ACC_W-1], acc_i}) + HALF;
    shr = rnd >>> RND_SH;
    if (shr > SMAX)      sat = {1'b0, {(OUT_W-1){1'b1}}};
    else if (shr < SMIN) sat = {1'b1, {(OUT_W-1){1'b0}}};
    else                 sat = shr[OUT_W-1:0];
    scl   = sat * $signed({1'b0, slope_i});
    res_o = (sat > 0) ? sat : OUT_W'(scl >>> SLOPE_W);
  end
endmodule

// File: rtl/conv_win_engine.sv
module conv_win_engine
  import cw_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int IMG_W  = 16,
  parameter int PIX_W  = 10,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 16,
  parameter int RND_SH = 4,
  localparam int NCOEF = N_IN * TAPS,
  localparam int CA_W  = $clog2(NCOEF)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    coef_we_i,
  input  logic [CA_W-1:0]         coef_addr_i,
  input  logic [COEF_W-1:0]       coef_data_i,
  input  logic [SLOPE_W-1:0]      slope_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic                    in_sof_i,
  input  logic [N_IN*PIX_W-1:0]   in_data_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [OUT_W-1:0]        out_data_o
);
  localparam int PROD_W = PIX_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NCOEF);
  localparam int COL_W  = $clog2(IMG_W);

  logic [COEF_W-1:0]            coef_q [NCOEF];
  logic [NCOEF*COEF_W-1:0]      coef_flat;
  logic [N_IN*TAPS*PIX_W-1:0]   win_all;
  logic signed [ACC_W-1:0]      acc;
  logic signed [OUT_W-1:0]      res;
  logic [COL_W-1:0]             col_q, eff_col;
  logic [1:0]                   row_q, eff_row;
  logic                         acc_in, win_ok;
  logic                         out_valid_q;
  logic [OUT_W-1:0]             out_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCOEF; i++) coef_q[i] <= '0;
    end else if (coef_we_i && (int'(coef_addr_i) < NCOEF)) begin
      coef_q[coef_addr_i] <= coef_data_i;
    end
  end

  for (genvar i = 0; i < NCOEF; i++) begin : g_cflat
    assign coef_flat[i*COEF_W +: COEF_W] = coef_q[i];
  end

  assign in_ready_o = !out_valid_q || out_ready_i;
  assign acc_in     = in_valid_i && in_ready_o;
  assign eff_col    = in_sof_i ? '0 : col_q;
  assign eff_row    = in_sof_i ? '0 : row_q;
  assign win_ok     = (eff_row == 2'd2) && (eff_col >= COL_W'(2));

  for (genvar m = 0; m < N_IN; m++) begin : g_map
    cw_line_window #(
      .IMG_W(IMG_W), .PIX_W(PIX_W), .COL_W(COL_W)
    ) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (acc_in),
      .clear_i (in_sof_i),
      .col_i   (eff_col),
      .px_i    (in_data_i[m*PIX_W +: PIX_W]),
      .win_o   (win_all[m*TAPS*PIX_W +: TAPS*PIX_W])
    );
  end

  cw_mac #(
    .N_IN(N_IN), .PIX_W(PIX_W), .COEF_W(COEF_W), .PROD_W(PROD_W), .ACC_W(ACC_W)
  ) u_mac (
    .win_i  (win_all),
    .coef_i (coef_flat),
    .acc_o  (acc)
  );

  cw_post #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .RND_SH(RND_SH)
  ) u_post (
    .acc_i   (acc),
    .slope_i (slope_i),
    .res_o   (res)
  );

  // row count saturates at 2: only "at least two rows above" matters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (acc_in) begin
      if (eff_col == COL_W'(IMG_W - 1)) begin
        col_q <= '0;
        row_q <= (eff_row == 2'd2) ? 2'd2 : eff_row + 2'd1;
      end else begin
        col_q <= eff_col + COL_W'(1);
        row_q <= eff_row;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (acc_in) begin
      out_valid_q <= win_ok;
      if (win_ok) out_data_q <= res;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
endmodule

// File: rtl/conv_win_engine_chk.sv
module conv_win_engine_chk #(
  parameter int IMG_W = 16,
  parameter int OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             in_sof_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_data_o
);
  localparam int COL_W = $clog2(IMG_W);

  logic [COL_W-1:0] k_col, e_col;
  logic [1:0]       k_row, e_row;
  logic             fire;

  assign fire  = in_valid_i && in_ready_o;
  assign e_col = in_sof_i ? '0 : k_col;
  assign e_row = in_sof_i ? '0 : k_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_col <= '0;
      k_row <= '0;
    end else if (fire) begin
      if (e_col == COL_W'(IMG_W - 1)) begin
        k_col <= '0;
        if (e_row != 2'd2) k_row <= e_row + 2'd1;
        else k_row <= e_row;
      end else begin
        k_col <= e_col + COL_W'(1);
        k_row <= e_row;
      end
    end
  end

  a_r1_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r9_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  a_r10_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));

  a_r4_top_rows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (e_row != 2'd2) |=> !out_valid_o);

  a_r5_left_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (e_col < COL_W'(2)) |=> !out_valid_o);

  a_r6_sof_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && in_sof_i |=> !out_valid_o);
endmodule

bind conv_win_engine conv_win_engine_chk #(
  .IMG_W(IMG_W), .OUT_W(OUT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_sof_i    (in_sof_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/tb_conv_win_engine.sv
module tb_conv_win_engine;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 4;
  localparam int W     = 8;
  localparam int H     = 5;
  localparam int PIX_W = 10;
  localparam int COEF_W = 10;
  localparam int OUT_W = 16;
  localparam int RS    = 4;
  localparam int NC    = N_IN * 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_we = 1'b0;
  logic [5:0] coef_addr = '0;
  logic [COEF_W-1:0] coef_data = '0;
  logic [7:0] slope = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_sof = 1'b0;
  logic [N_IN*PIX_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [OUT_W-1:0] out_data;

  conv_win_engine #(
    .N_IN(N_IN), .IMG_W(W), .PIX_W(PIX_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .RND_SH(RS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .slope_i(slope),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sof_i(in_sof), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cf [NC];
  int img [N_IN][H][W];
  int exp_q [$];
  int acc_cnt = 0, cyc = 0, stall = 0;
  bit lat_chk = 0, seen_first = 0, hold_pend = 0, last_fire = 0, done = 0;
  logic [OUT_W-1:0] hold_data = '0;
  string tag = "";

  task automatic check(bit ok, string t, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, expv);
    end
  endtask

  function automatic int pixv(int mode, int seed, int m, int y, int x);
    int v;
    case (mode)
      0: begin
        v = m*131 + y*29 + x*17 + seed*71 + 5;
        v = (v*v*7 + seed*3 + m) % 1024;
        return v - 512;
      end
      1: return ((y*W + x)*3 + m*5 + seed) % 81 - 40;
      default: return 511;
    endcase
  endfunction

  function automatic int coefv(int mode, int i);
    case (mode)
      0: return ((i*97 + 13)*(i + 7)) % 1024 - 512;
      1: return (i == 19) ? 1 : 0;
      2: return 511;
      3: return -512;
      default: return (i*37 + 5) % 15 - 7;
    endcase
  endfunction

  function automatic int post(int acc, int s);
    int y;
    y = (acc + (1 << (RS-1))) >>> RS;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    if (y <= 0) y = (y * s) >>> 8;
    return y;
  endfunction

  task automatic step();
    int sdata, e;
    out_ready = (stall == 0) ? 1'b1 : ((cyc % 4) != 1 && (cyc % 7) != 0);
    #1;
    sdata = int'($signed(out_data));
    if (hold_pend)
      check(out_valid && out_data == hold_data, "R9 output held under stall", sdata, int'($signed(hold_data)));
    if (out_valid && !out_ready)
      check(!in_ready, "R9 input blocked while output stalled", int'(in_ready), 0);
    if (out_valid && lat_chk && !seen_first) begin
      seen_first = 1;
      check(acc_cnt == 2*W + 3, "R4 R10 first output position", acc_cnt, 2*W + 3);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected output", sdata, 0);
      else begin
        e = exp_q.pop_front();
        check(sdata == e, tag, sdata, e);
      end
    end
    hold_pend = out_valid && !out_ready;
    hold_data = out_data;
    last_fire = in_valid && in_ready;
    if (last_fire) acc_cnt++;
    cyc++;
    @(negedge clk);
  endtask

  task automatic load_coefs(int mode);
    for (int i = 0; i < NC; i++) begin
      cf[i] = coefv(mode, i);
      coef_we = 1'b1;
      coef_addr = 6'(i);
      coef_data = COEF_W'(cf[i]);
      step();
    end
    coef_we = 1'b0;
    step();
  endtask

  task automatic send_frame(int mode, int seed, int n_send, int st, bit bubble);
    int a;
    for (int m = 0; m < N_IN; m++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++)
          img[m][y][x] = pixv(mode, seed, m, y, x);
    for (int p = 0; p < n_send; p++) begin
      int y = p / W, x = p % W;
      if (y >= 2 && x >= 2) begin
        a = 0;
        for (int m = 0; m < N_IN; m++)
          for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
              a += img[m][y-2+r][x-2+c] * cf[m*9 + r*3 + c];
        exp_q.push_back(post(a, int'(slope)));
      end
    end
    stall = st;
    acc_cnt = 0;
    seen_first = 0;
    for (int p = 0; p < n_send; p++) begin
      if (bubble && (p % 5 == 3)) begin
        in_valid = 1'b0;
        step();
      end
      for (int m = 0; m < N_IN; m++)
        in_data[m*PIX_W +: PIX_W] = PIX_W'(img[m][p / W][p % W]);
      in_sof = (p == 0);
      in_valid = 1'b1;
      step();
      while (!last_fire) step();
    end
    in_valid = 1'b0;
    in_sof = 1'b0;
    for (int k = 0; k < 60 && exp_q.size() > 0; k++) step();
    check(exp_q.size() == 0, "R5 R6 all expected outputs delivered", exp_q.size(), 0);
    exp_q.delete();
    stall = 0;
    for (int k = 0; k < 3; k++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: stream hung actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(!out_valid, "R1 out_valid low in reset", int'(out_valid), 0);
    check(in_ready, "R1 in_ready high in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 idle after reset", int'(out_valid), 0);

    slope = 8'd128;
    load_coefs(1);
    tag = "R2 R3 R7 single-tap rounding";
    lat_chk = 1;
    send_frame(1, 0, W*H, 0, 0);
    lat_chk = 0;

    load_coefs(0);
    slope = 8'd77;
    tag = "R3 R8 random data with stalls";
    send_frame(0, 1, W*H, 1, 0);
    tag = "R3 random data with input bubbles";
    send_frame(0, 2, W*H, 0, 1);

    load_coefs(2);
    slope = 8'd200;
    tag = "R7 positive saturation";
    send_frame(2, 0, W*H, 0, 0);

    load_coefs(3);
    tag = "R7 R8 negative saturation then slope";
    send_frame(2, 0, W*H, 1, 0);

    load_coefs(4);
    slope = 8'd0;
    tag = "R8 zero slope";
    send_frame(0, 3, W*H, 0, 0);

    load_coefs(0);
    slope = 8'd255;
    tag = "R6 truncated frame";
    send_frame(0, 4, 2*W + 5, 0, 0);
    tag = "R6 restart after start-of-frame";
    send_frame(0, 5, W*H, 1, 1);
    tag = "R6 second restart back-to-back";
    send_frame(1, 7, W*H, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule